// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner with Lock Detect

This block sits behind a clock-and-data recovery front end on the receive side of a 24-bit serial link. The front end hands it one recovered bit per strobe on `bit_en`. Every 28-bit frame on the wire carries a fixed clock pair: a 1 immediately followed by a 0. The aligner looks for that pair in ordinary payload traffic. It needs no training pattern from the far end. Once the pair has held at one offset for several frames, the aligner declares lock. It then rebuilds each parallel word, removing the DC-balance inversion and checking an even-parity bit.

Frame layout, in arrival order: position 0 is the clock-pair 1, and position 1 is the clock-pair 0. Positions 2 to 25 carry the payload, with payload bit 0 arriving first. Position 26 is the balance flag: 1 means the payload was sent inverted. Position 27 is the parity bit. It is chosen so that positions 2 to 27 XOR to zero.

On the parallel side the block produces the word, a recovered parallel clock and a lock flag. High impedance is not built inside the block. Each output group has a drive-enable output instead, and the pad ring applies it. One enable covers the data and the recovered clock together, and a second covers the lock flag.

Top module: `emb_clk_aligner`

## Requirements
- R1: After reset, and whenever the aligner is not locked, `lock_o` is 0 and `out_drive_o` is 0. `lock_drive_o` is 1 while `pwr_on` is 1. `par_err_o` is 0 after reset.
- R2: Alignment is found in payload traffic that carries no special pattern. A candidate offset is a 28-bit window with 1 at position 0, 0 at position 1 and even parity over positions 2 to 27. Lock is declared at the end of the 4th consecutive frame that passes at the same offset, and not earlier.
- R3: In the clock cycle after the strobe that completes the locking frame, `lock_o` and `out_drive_o` both rise, and `data_o` already holds that frame's word. After that, every frame completed while locked puts its word on `data_o`.
- R4: When the balance flag (position 26) is 1, the payload is inverted back before it reaches `data_o`. When the flag is 0, the payload passes unchanged.
- R5: While locked, a single frame without the 1-then-0 pair drops `lock_o` in the next cycle and restarts the search. A clean run of frames then re-locks after 4 frames.
- R6: During confirmation, a frame with a parity failure abandons the candidate offset. Lock then needs 4 fresh consecutive good frames.
- R7: While locked, a frame that has the clock pair but fails parity keeps lock. It raises `par_err_o` for exactly one cycle, and that frame's word is still output.
- R8: With `edge_sel` = 1, `data_o` changes in the same cycle that `rclk_o` falls. With `edge_sel` = 0, `data_o` changes in the same cycle that `rclk_o` rises.
- R9: `rclk_o` has a period of 28 strobes and is at its high level for 14 of them. `data_o` changes only on the strobe that ends a frame.
- R10: `out_en` = 0 clears `out_drive_o`. `lock_drive_o` stays at 1, and `lock_o` keeps tracking lock, including a loss of lock.
- R11: `pwr_on` = 0 clears both drive enables at once and resets acquisition. After power returns, lock again needs 4 good frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on | input | 1 | 0 = power-down: outputs released, acquisition held in reset |
| out_en | input | 1 | 0 releases the data and recovered-clock outputs |
| edge_sel | input | 1 | 1: data changes on falling `rclk_o`; 0: on rising |
| bit_en | input | 1 | Strobe marking a valid serial bit |
| bit_in | input | 1 | Serial bit, sampled when `bit_en` is 1 |
| data_o | output | DATA_W | Recovered parallel word |
| rclk_o | output | 1 | Recovered parallel clock |
| out_drive_o | output | 1 | Drive enable for `data_o` and `rclk_o` |
| lock_o | output | 1 | Lock flag |
| lock_drive_o | output | 1 | Drive enable for `lock_o` |
| par_err_o | output | 1 | One-cycle pulse on a parity failure while locked |

## Verification
Acquisition is first driven with varied payload words, placed behind a run of idle zeros. This shows that the first valid window is the true boundary, and that lock waits for exactly the 4th frame. Zero-payload frames are used after every disturbance: a missing clock edge, a parity failure during confirmation, and power-down. Their only 1 bits are the frame starts, so no false candidate can form. The lock cycle therefore separates a restarted search from one that carried its count over. Inverted and plain payloads, streamed under both clock polarities, show whether the balance undo and the edge relation each hold independently.

// File: rtl/fa_pkg.sv
// Shared types for the embedded-clock frame aligner.
package fa_pkg;
    // Acquisition state: searching, confirming a candidate offset, locked.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } sync_state_e;
endpackage

// File: rtl/fa_shift_window.sv
// Serial-to-window stage. Keeps the last FRAME_W bits, oldest at index 0,
// and decodes the window that includes the bit arriving on this strobe.
// Assumes the frame layout: [0]=1, [1]=0, payload, balance flag, parity.
module fa_shift_window #(
    parameter int FRAME_W = 28,
    parameter int DATA_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              pair_ok,
    output logic              par_ok,
    output logic [DATA_W-1:0] word
);
    localparam int FLAG_POS = DATA_W + 2;

    logic [FRAME_W-1:0] sr_q;
    logic [FRAME_W-1:0] sr_nxt;
    logic               flag;

    // Window as it will look once the present bit is taken in.
    always_comb sr_nxt = {bit_in, sr_q[FRAME_W-1:1]};

    // Shift a new bit in on each strobe; cleared on reset or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr_q <= '0;
        end else if (bit_en) begin
            sr_q <= sr_nxt;
        end
    end

    // Decode clock pair, parity and balance flag of the candidate window.
    always_comb begin
        pair_ok = sr_nxt[0] & ~sr_nxt[1];
        par_ok  = ~(^sr_nxt[FRAME_W-1:2]);
        flag    = sr_nxt[FLAG_POS];
    end

    // Undo the balance inversion bit by bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_unbal
        assign word[i] = sr_nxt[i+2] ^ flag;
    end
endmodule

// File: rtl/fa_sync_fsm.sv
// Frame synchroniser. Tests each strobe position as a boundary while hunting,
// confirms a candidate over LOCK_FRAMES frames, and then tracks it while locked.
// Assumes pair_ok/par_ok describe the window completed by the present strobe.
module fa_sync_fsm
    import fa_pkg::*;
#(
    parameter int FRAME_W     = 28,
    parameter int LOCK_FRAMES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       bit_en,
    input  logic                       pair_ok,
    input  logic                       par_ok,
    output logic                       locked,
    output logic                       load,
    output logic                       err_pulse,
    output logic [$clog2(FRAME_W)-1:0] pos
);
    localparam int                POS_W     = $clog2(FRAME_W);
    localparam int                CNT_W     = $clog2(LOCK_FRAMES + 1);
    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0]  CNT_FINAL = CNT_W'(LOCK_FRAMES - 1);
    localparam bit                ONE_SHOT  = (LOCK_FRAMES == 1);

    sync_state_e       state_q;
    logic [POS_W-1:0]  pos_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              err_q;
    logic              win_ok;
    logic              at_end;

    // Helper terms: full window validity and expected boundary.
    always_comb begin
        win_ok = pair_ok & par_ok;
        at_end = (pos_q == POS_LAST);
    end

    // Word load: the locking frame, or any locked frame that keeps its pair.
    always_comb begin
        load = 1'b0;
        if (bit_en) begin
            unique case (state_q)
                ST_HUNT:    load = win_ok & ONE_SHOT;
                ST_CONFIRM: load = at_end & win_ok & (cnt_q == CNT_FINAL);
                ST_LOCKED:  load = at_end & pair_ok;
                default:    load = 1'b0;
            endcase
        end
    end

    // State, frame position, confirmation count and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (bit_en) begin
                pos_q <= at_end ? '0 : pos_q + 1'b1;
                unique case (state_q)
                    ST_HUNT: begin
                        if (win_ok) begin
                            pos_q   <= '0;
                            cnt_q   <= CNT_W'(1);
                            state_q <= ONE_SHOT ? ST_LOCKED : ST_CONFIRM;
                        end
                    end
                    ST_CONFIRM: begin
                        if (at_end) begin
                            if (!win_ok) begin
                                state_q <= ST_HUNT;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                                if (cnt_q == CNT_FINAL) state_q <= ST_LOCKED;
                            end
                        end
                    end
                    ST_LOCKED: begin
                        if (at_end) begin
                            if (!pair_ok)     state_q <= ST_HUNT;
                            else if (!par_ok) err_q   <= 1'b1;
                        end
                    end
                    default: state_q <= ST_HUNT;
                endcase
            end
        end
    end

    assign locked    = (state_q == ST_LOCKED);
    assign err_pulse = err_q;
    assign pos       = pos_q;
endmodule

// File: rtl/fa_out_stage.sv
// Parallel output stage: word register, recovered clock from the frame
// position, and drive enables for the two output groups.
// Assumes pos is 0 right after the strobe that ends a frame.
module fa_out_stage #(
    parameter int FRAME_W = 28,
    parameter int DATA_W  = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       load,
    input  logic [DATA_W-1:0]          word,
    input  logic [$clog2(FRAME_W)-1:0] pos,
    input  logic                       locked,
    input  logic                       pwr_on,
    input  logic                       out_en,
    input  logic                       edge_sel,
    output logic [DATA_W-1:0]          data_o,
    output logic                       rclk_o,
    output logic                       out_drive_o,
    output logic                       lock_o,
    output logic                       lock_drive_o
);
    localparam int               POS_W    = $clog2(FRAME_W);
    localparam logic [POS_W-1:0] POS_HALF = POS_W'(FRAME_W / 2);

    logic [DATA_W-1:0] data_q;
    logic              late_half;

    // Hold the last loaded word; cleared on reset or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= word;
        end
    end

    // Recovered clock: low for the first half of the frame, high for the second, then polarity applied.
    always_comb begin
        late_half = (pos >= POS_HALF);
        rclk_o    = late_half ~^ edge_sel;
    end

    // Drive enables: data/clock need lock and enable, lock flag needs only power.
    always_comb begin
        out_drive_o  = pwr_on & out_en & locked;
        lock_drive_o = pwr_on;
    end

    assign data_o = data_q;
    assign lock_o = locked;
endmodule

// File: rtl/emb_clk_aligner.sv
// Top of the embedded-clock frame aligner: window, synchroniser, output stage.
// Assumes one serial bit per bit_en strobe, from an external recovery stage.
module emb_clk_aligner #(
    parameter int DATA_W      = 24,
    parameter int LOCK_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              out_en,
    input  logic              edge_sel,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data_o,
    output logic              rclk_o,
    output logic              out_drive_o,
    output logic              lock_o,
    output logic              lock_drive_o,
    output logic              par_err_o
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int POS_W   = $clog2(FRAME_W);

    logic              clear;
    logic              pair_ok;
    logic              par_ok;
    logic [DATA_W-1:0] word;
    logic              locked;
    logic              load;
    logic [POS_W-1:0]  pos;

    // Power-down acts as a synchronous acquisition reset.
    always_comb clear = ~pwr_on;

    fa_shift_window #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) win_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .bit_en(bit_en), .bit_in(bit_in),
        .pair_ok(pair_ok), .par_ok(par_ok), .word(word)
    );

    fa_sync_fsm #(.FRAME_W(FRAME_W), .LOCK_FRAMES(LOCK_FRAMES)) sync_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .bit_en(bit_en),
        .pair_ok(pair_ok), .par_ok(par_ok), .locked(locked), .load(load),
        .err_pulse(par_err_o), .pos(pos)
    );

    fa_out_stage #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) out_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .word(word),
        .pos(pos), .locked(locked), .pwr_on(pwr_on), .out_en(out_en),
        .edge_sel(edge_sel), .data_o(data_o), .rclk_o(rclk_o),
        .out_drive_o(out_drive_o), .lock_o(lock_o), .lock_drive_o(lock_drive_o)
    );
endmodule

// File: rtl/fa_aligner_chk.sv
// Property checker for emb_clk_aligner, attached through bind.
module fa_aligner_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_on,
    input logic              bit_en,
    input logic [DATA_W-1:0] data_o,
    input logic              out_drive_o,
    input logic              lock_o,
    input logic              lock_drive_o,
    input logic              par_err_o
);
    // R7
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |=> !par_err_o);

    // R7
    err_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> lock_o);

    // R2
    lock_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(bit_en));

    // R5
    lock_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_o) && $past(pwr_on)) |-> $past(bit_en));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && pwr_on) |=> $stable(data_o));

    // R11
    powerdown_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (!lock_drive_o && !out_drive_o));
endmodule

bind emb_clk_aligner fa_aligner_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .bit_en(bit_en),
    .data_o(data_o), .out_drive_o(out_drive_o), .lock_o(lock_o),
    .lock_drive_o(lock_drive_o), .par_err_o(par_err_o)
);

// File: tb/emb_clk_aligner_tb_top.sv
module emb_clk_aligner_tb_top;
    localparam int DW = 24;
    localparam int FW = DW + 4;

    logic          clk = 1'b0;
    logic          rst_n, pwr_on, out_en, edge_sel, bit_en, bit_in;
    logic [DW-1:0] data_o;
    logic          rclk_o, out_drive_o, lock_o, lock_drive_o, par_err_o;

    always #4 clk = ~clk;

    emb_clk_aligner #(.DATA_W(DW), .LOCK_FRAMES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .out_en(out_en),
        .edge_sel(edge_sel), .bit_en(bit_en), .bit_in(bit_in),
        .data_o(data_o), .rclk_o(rclk_o), .out_drive_o(out_drive_o),
        .lock_o(lock_o), .lock_drive_o(lock_drive_o), .par_err_o(par_err_o)
    );

    int            checks = 0;
    int            fails  = 0;
    int            err_seen = 0;
    int            rclk_hi = 0;
    bit            mon_on = 1'b0;
    bit            done = 1'b0;
    logic [DW-1:0] exp_q[$];
    logic          prev_rclk = 1'b0;
    logic          prev_oe = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Transmit-side frame model: [0]=1,[1]=0,[2..25]=payload,[26]=flag,[27]=parity.
    function automatic logic [FW-1:0] mk_frame(input logic [DW-1:0] d, input bit inv,
                                               input bit bad_par, input bit no_edge);
        logic [FW-1:0] f;
        f[0]       = 1'b1;
        f[1]       = no_edge;
        f[DW+1:2]  = inv ? ~d : d;
        f[FW-2]    = inv;
        f[FW-1]    = (^f[FW-2:2]) ^ bad_par;
        return f;
    endfunction

    task automatic send_bit(input logic b);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        if (rclk_o) rclk_hi++;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [DW-1:0] d, input bit inv, input bit bad_par,
                              input bit no_edge, input bit push);
        logic [FW-1:0] f;
        f = mk_frame(d, inv, bad_par, no_edge);
        if (push) exp_q.push_back(d);
        for (int i = 0; i < FW; i++) send_bit(f[i]);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    // Scoreboard monitor: pops an expected word at each new-word point.
    always @(negedge clk) begin
        if (mon_on && out_drive_o &&
            (!prev_oe || (rclk_o != prev_rclk && rclk_o == !edge_sel))) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3 unexpected word actual=%0h expected=none", data_o);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (data_o !== e || lock_o !== 1'b1) begin
                    fails++;
                    $display("FAIL R4/R8 word actual=%0h expected=%0h", data_o, e);
                end
            end
        end
        if (par_err_o) err_seen++;
        prev_rclk <= rclk_o;
        prev_oe   <= out_drive_o;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int e0;
        rst_n = 1'b0; pwr_on = 1'b1; out_en = 1'b1; edge_sel = 1'b1;
        bit_en = 1'b0; bit_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(lock_o == 1'b0, "R1 lock", lock_o, 0);
        chk(out_drive_o == 1'b0, "R1 out_drive", out_drive_o, 0);
        chk(lock_drive_o == 1'b1, "R1 lock_drive", lock_drive_o, 1);
        chk(par_err_o == 1'b0, "R1 par_err", par_err_o, 0);

        // R2 acquisition from varied payload, no training pattern
        mon_on = 1'b1;
        send_idle(13);
        send_frame(24'hA5C31E, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(24'h0F0F33, 1'b1, 1'b0, 1'b0, 1'b0);
        send_frame(24'h5A6B7C, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(lock_o == 1'b0, "R2 no lock after 3 frames", lock_o, 0);
        chk(out_drive_o == 1'b0, "R1 unlocked drive", out_drive_o, 0);
        send_frame(24'h123456, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(lock_o == 1'b1, "R2 lock after 4 frames", lock_o, 1);
        chk(out_drive_o == 1'b1, "R3 drive with lock", out_drive_o, 1);
        chk(data_o == 24'h123456, "R3 word with lock", data_o, 24'h123456);
        chk(rclk_o == 1'b0, "R8 rclk low at new word (edge_sel=1)", rclk_o, 0);

        // R4 streaming with both balance settings
        send_frame(24'hFFFFFF, 1'b1, 1'b0, 1'b0, 1'b1);
        send_frame(24'h000001, 1'b0, 1'b0, 1'b0, 1'b1);
        send_frame(24'hC0FFEE, 1'b1, 1'b0, 1'b0, 1'b1);
        rclk_hi = 0;
        send_frame(24'h3C3C3C, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(rclk_hi == 14, "R9 rclk high strobes per frame", rclk_hi, 14);
        chk(exp_q.size() == 0, "R4 all words seen", exp_q.size(), 0);

        // R7 parity failure while locked
        e0 = err_seen;
        send_frame(24'h777000, 1'b0, 1'b1, 1'b0, 1'b1);
        chk(err_seen - e0 == 1, "R7 one-cycle error pulse", err_seen - e0, 1);
        chk(lock_o == 1'b1, "R7 lock kept", lock_o, 1);
        send_frame(24'h00ABCD, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(err_seen - e0 == 1, "R7 no extra pulse", err_seen - e0, 1);

        // R8 opposite clock polarity
        mon_on = 1'b0;
        edge_sel = 1'b0;
        repeat (2) @(negedge clk);
        mon_on = 1'b1;
        send_frame(24'h89ABCD, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(rclk_o == 1'b1, "R8 rclk high at new word (edge_sel=0)", rclk_o, 1);
        send_frame(24'hFEDCBA, 1'b1, 1'b0, 1'b0, 1'b1);
        rclk_hi = 0;
        send_frame(24'h246813, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(rclk_hi == 14, "R9 rclk duty inverted polarity", rclk_hi, 14);
        chk(exp_q.size() == 0, "R8 all words seen", exp_q.size(), 0);

        // R10 output enable low
        mon_on = 1'b0;
        out_en = 1'b0;
        @(negedge clk);
        chk(out_drive_o == 1'b0, "R10 data drive off", out_drive_o, 0);
        chk(lock_drive_o == 1'b1, "R10 lock still driven", lock_drive_o, 1);
        chk(lock_o == 1'b1, "R10 lock still high", lock_o, 1);

        // R5 missing clock edge drops lock, seen while enable is low
        send_frame(24'h5A5A5A, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(lock_o == 1'b0, "R5 lock lost on missing edge", lock_o, 0);
        chk(lock_drive_o == 1'b1, "R10 lock flag tracks", lock_drive_o, 1);
        out_en = 1'b1;
        @(negedge clk);
        chk(out_drive_o == 1'b0, "R1 no drive while unlocked", out_drive_o, 0);
        send_idle(33);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(lock_o == 1'b0, "R5 search restarted", lock_o, 0);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(lock_o == 1'b1, "R5 relock after 4 frames", lock_o, 1);

        // R11 power-down
        pwr_on = 1'b0;
        #1;
        chk(lock_drive_o == 1'b0, "R11 lock drive off", lock_drive_o, 0);
        chk(out_drive_o == 1'b0, "R11 data drive off", out_drive_o, 0);
        @(negedge clk);
        @(negedge clk);
        pwr_on = 1'b1;
        @(negedge clk);
        chk(lock_o == 1'b0, "R11 acquisition reset", lock_o, 0);
        chk(lock_drive_o == 1'b1, "R11 lock driven again", lock_drive_o, 1);
        chk(data_o == '0, "R11 word cleared", data_o, 0);

        // R6 parity failure during confirmation, R11 relock needs 4 frames
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(lock_o == 1'b0, "R11 no lock after 3 frames", lock_o, 0);
        send_frame(24'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(lock_o == 1'b0, "R6 bad parity blocks lock", lock_o, 0);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(lock_o == 1'b0, "R6 count restarted", lock_o, 0);
        send_frame(24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(lock_o == 1'b1, "R6 lock after fresh 4 frames", lock_o, 1);

        // R3 streaming resumes after relock
        @(negedge clk);
        mon_on = 1'b1;
        send_frame(24'hBEEF01, 1'b1, 1'b0, 1'b0, 1'b1);
        send_frame(24'h13579B, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(exp_q.size() == 0, "R3 words after relock", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule